// File: doc/BRIEF.md
# Serial EEPROM Command Shifter

This block runs a single access to a three-wire serial configuration EEPROM without software involvement. The caller presents a command word and the index of its most significant bit, then pulses `start`. The block raises chip select, gives one idle clock-high phase, and then shifts the command out MSB first on a generated shift clock. Every command bit also brings one bit back: at the end of each clock-high phase the EEPROM's serial output is sampled into the low end of a result register.

When the last bit has been clocked, the block drives the shift clock low for one more phase with chip select still high, then releases chip select. `busy` covers the whole access. A one-cycle `done` pulse marks the cycle in which `result` holds the bits gathered during that access. Every phase of the shift clock lasts `PHASE_CYC` system clock cycles. Choose this value so that each phase lasts at least one microsecond; two microseconds gives comfortable margin.

Top module: `ee_cmd_shifter`

## Requirements
- R1: After reset `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are low and `result` is zero.
- R2: An accepted start opens the access with `ee_cs` high and `ee_sk` low for one phase, then `ee_sk` high for one phase. `ee_di` is low in both phases.
- R3: Every phase of `ee_sk`, whether low or high, lasts exactly `PHASE_CYC` clock cycles while `ee_cs` is high.
- R4: Command bits go out MSB first, from `cmd[cmd_len]` down to `cmd[0]`, which is `cmd_len`+1 bits in all. Each bit is placed on `ee_di` for a low phase followed by a high phase, and it holds through both. Bits of `cmd` above `cmd_len` are never sent.
- R5: In the last cycle of each bit's high phase, `ee_do` is shifted into `result[0]` and the earlier bits move one place left. `result` is cleared when a start is accepted. After the access, bit 0 holds the sample of the last bit and the bits above `cmd_len` are zero.
- R6: The access closes with `ee_sk` low, `ee_di` low and `ee_cs` still high for one phase, after which `ee_cs` goes low.
- R7: `busy` rises in the cycle after a start is accepted. It stays high exactly as long as `ee_cs`, and it is low when `ee_cs` is low.
- R8: `done` is high for exactly one cycle: the first cycle with `ee_cs` low after an access. `result` then holds its value until the next accepted start.
- R9: A `start` while `busy` is high is ignored. The running access keeps its waveform and result, and no new command is captured. A `start` in the `done` cycle is accepted.
- R10: `ee_sk` is never high while `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an access; sampled only while idle |
| cmd | input | CMD_W | Command bits to send |
| cmd_len | input | LEN_W | Index of the first (most significant) bit to send |
| busy | output | 1 | High during an access |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | CMD_W | Bits sampled from the EEPROM, last one in bit 0 |
| ee_sk | output | 1 | Shift clock to the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bound checker watches several properties on every cycle:
- the run length of each shift-clock phase and of the closing phase;
- that the clock is never high without chip select;
- that data is held during a high phase;
- the single-cycle `done` and its position at the fall of chip select;
- that `busy` rises only after a start;
- that `result` stays stable while idle.

Only the bench's reference model can show the bit order on the data line, the exact bit gathered into each place of `result`, the truncation at `cmd_len`, and the refusal of a start during an access. It shows these across single-bit, full-width, held-start and back-to-back accesses.

// File: rtl/ee_shift_pkg.sv
package ee_shift_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_OPEN_LO = 3'd1,
        ST_OPEN_HI = 3'd2,
        ST_BIT_LO  = 3'd3,
        ST_BIT_HI  = 3'd4,
        ST_CLOSE   = 3'd5
    } ee_state_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_pins_t;

    // Pin levels for a sequencer state and the command bit being sent.
    function automatic ee_pins_t pins_for(ee_state_e s, logic bitv);
        ee_pins_t p;
        p.cs = (s != ST_IDLE);
        p.sk = (s == ST_OPEN_HI) || (s == ST_BIT_HI);
        p.di = ((s == ST_BIT_LO) || (s == ST_BIT_HI)) && bitv;
        return p;
    endfunction

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic last
);
    generate
        if (PHASE_CYC <= 1) begin : g_single
            assign last = active;
        end else begin : g_count
            localparam int CNT_W = $clog2(PHASE_CYC);
            localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PHASE_CYC - 1);
            logic [CNT_W-1:0] cnt;

            assign last = active && (cnt == CNT_MAX);

            always_ff @(posedge clk) begin
                if (rst || !active || last) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ee_seq.sv
module ee_seq
    import ee_shift_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             phase_last,
    output ee_state_e        state,
    output logic [LEN_W-1:0] idx,
    output logic             accept,
    output logic             sample_en,
    output logic             done
);
    ee_state_e state_n;

    assign accept    = start && (state == ST_IDLE);
    assign sample_en = (state == ST_BIT_HI) && phase_last;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (accept)     state_n = ST_OPEN_LO;
            ST_OPEN_LO: if (phase_last) state_n = ST_OPEN_HI;
            ST_OPEN_HI: if (phase_last) state_n = ST_BIT_LO;
            ST_BIT_LO:  if (phase_last) state_n = ST_BIT_HI;
            ST_BIT_HI:  if (phase_last) state_n = (idx == '0) ? ST_CLOSE : ST_BIT_LO;
            ST_CLOSE:   if (phase_last) state_n = ST_IDLE;
            default:                    state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            state <= state_n;
            done  <= (state == ST_CLOSE) && phase_last;
            if (accept) begin
                idx <= cmd_len;
            end else if (sample_en && (idx != '0)) begin
                idx <= idx - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ee_shift_reg.sv
module ee_shift_reg #(
    parameter int CMD_W = 32,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CMD_W-1:0] cmd,
    input  logic [LEN_W-1:0] idx,
    input  logic             sample_en,
    input  logic             ee_do,
    output logic             cur_bit,
    output logic [CMD_W-1:0] result
);
    logic [CMD_W-1:0] cmd_q;

    assign cur_bit = cmd_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            result <= '0;
        end else if (accept) begin
            cmd_q  <= cmd;
            result <= '0;
        end else if (sample_en) begin
            result <= {result[CMD_W-2:0], ee_do};
        end
    end
endmodule

// File: rtl/ee_cmd_shifter.sv
module ee_cmd_shifter
    import ee_shift_pkg::*;
#(
    parameter int CMD_W     = 32,
    parameter int PHASE_CYC = 4,
    localparam int LEN_W    = (CMD_W > 1) ? $clog2(CMD_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             busy,
    output logic             done,
    output logic [CMD_W-1:0] result,
    output logic             ee_sk,
    output logic             ee_cs,
    output logic             ee_di,
    input  logic             ee_do
);
    ee_state_e        state;
    logic [LEN_W-1:0] idx;
    logic             accept;
    logic             sample_en;
    logic             phase_last;
    logic             cur_bit;
    ee_pins_t         pins;

    ee_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (state != ST_IDLE),
        .last   (phase_last)
    );

    ee_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_len    (cmd_len),
        .phase_last (phase_last),
        .state      (state),
        .idx        (idx),
        .accept     (accept),
        .sample_en  (sample_en),
        .done       (done)
    );

    ee_shift_reg #(.CMD_W(CMD_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd       (cmd),
        .idx       (idx),
        .sample_en (sample_en),
        .ee_do     (ee_do),
        .cur_bit   (cur_bit),
        .result    (result)
    );

    assign pins  = pins_for(state, cur_bit);
    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;
    assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/ee_shift_chk.sv
module ee_shift_chk #(
    parameter int CMD_W     = 32,
    parameter int PHASE_CYC = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CMD_W-1:0] result,
    input logic             ee_sk,
    input logic             ee_cs,
    input logic             ee_di
);
    logic [31:0] run_len;
    logic        prev_sk_q;
    logic        prev_cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '0;
            prev_sk_q <= 1'b0;
            prev_cs_q <= 1'b0;
        end else begin
            if (ee_cs && prev_cs_q && (ee_sk == prev_sk_q)) begin
                run_len <= run_len + 1;
            end else begin
                run_len <= 32'd1;
            end
            prev_sk_q <= ee_sk;
            prev_cs_q <= ee_cs;
        end
    end

    // R3: each shift-clock phase inside an access is PHASE_CYC cycles long
    a_r3_phase_len: assert property (@(posedge clk) disable iff (rst)
        (ee_cs && prev_cs_q && (ee_sk != prev_sk_q)) |-> (run_len == PHASE_CYC));

    // R6: the closing low phase lasts one phase before chip select drops
    a_r6_close_len: assert property (@(posedge clk) disable iff (rst)
        (!ee_cs && prev_cs_q) |-> (run_len == PHASE_CYC && !prev_sk_q));

    // R10: no clock without chip select
    a_r10_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    // R4: data holds through a high phase
    a_r4_di_hold_high: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && prev_sk_q) |-> $stable(ee_di));

    // R8: done is a single pulse at the fall of chip select
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_at_cs_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ee_cs && prev_cs_q));

    // R7: busy only starts after a start request
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R8: result holds while idle and no start arrives
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));
endmodule

bind ee_cmd_shifter ee_shift_chk #(.CMD_W(CMD_W), .PHASE_CYC(PHASE_CYC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .ee_sk  (ee_sk),
    .ee_cs  (ee_cs),
    .ee_di  (ee_di)
);

// File: tb/sim_ee_cmd_shifter.sv
module sim_ee_cmd_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 32;
    localparam int LW = 5;
    localparam int P  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] cmd = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          ee_do = 1'b0;
    logic          busy, done, ee_sk, ee_cs, ee_di;
    logic [CW-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // expected per-cycle entries: {sample, cs, sk, di}
    logic [3:0]    expq[$];
    logic [CW-1:0] exp_res = '0;
    bit            done_due = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_cmd_shifter #(.CMD_W(CW), .PHASE_CYC(P)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .cmd_len(cmd_len),
        .busy(busy), .done(done), .result(result),
        .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do)
    );

    task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load(logic [CW-1:0] c, int len);
        for (int k = 0; k < P; k++) expq.push_back(4'b0100);
        for (int k = 0; k < P; k++) expq.push_back(4'b0110);
        for (int b = len; b >= 0; b--) begin
            for (int k = 0; k < P; k++) expq.push_back({3'b010, c[b]});
            for (int k = 0; k < P; k++) expq.push_back({(k == P-1), 2'b11, c[b]});
        end
        for (int k = 0; k < P; k++) expq.push_back(4'b0100);
    endtask

    // one clock: compare this cycle against the model, then drive the next inputs
    task automatic step(bit st, logic [CW-1:0] c, int len);
        bit was_empty;
        bit samp;
        bit due_next;
        logic [3:0] e;
        @(negedge clk);
        was_empty = (expq.size() == 0);
        samp = 0;
        if (was_empty) begin
            chk("R1/R6 cs idle", CW'(ee_cs), '0);
            chk("R10 sk idle", CW'(ee_sk), '0);
            chk("R1 di idle", CW'(ee_di), '0);
            chk("R7 busy idle", CW'(busy), '0);
            chk("R8 done", CW'(done), CW'(done_due));
            chk("R5/R8 result", result, exp_res);
        end else begin
            e = expq.pop_front();
            samp = e[3];
            chk("R2/R6 cs", CW'(ee_cs), CW'(e[2]));
            chk("R3 sk", CW'(ee_sk), CW'(e[1]));
            chk("R4 di", CW'(ee_di), CW'(e[0]));
            chk("R7 busy", CW'(busy), 1);
            chk("R8 done low", CW'(done), '0);
        end
        due_next = !was_empty && (expq.size() == 0);
        ee_do = 1'($urandom);
        if (samp) exp_res = {exp_res[CW-2:0], ee_do};
        start = st;
        cmd = c;
        cmd_len = LW'(len);
        if (st && was_empty && !rst) begin
            load(c, len);
            exp_res = '0;
        end
        done_due = due_next;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0);
    endtask

    task automatic run_access(logic [CW-1:0] c, int len);
        step(1, c, len);
        while (expq.size() != 0) step(0, $urandom, 0);
        step(0, '0, 0);
    endtask

    initial begin
        // R1: outputs idle during and right after reset
        for (int i = 0; i < 3; i++) step(0, '0, 0);
        rst = 1'b0;
        idle(2);

        run_access(32'h1, 0);                 // R4: single bit
        run_access(32'h0000_00A5, 7);          // R4/R5: byte pattern
        run_access(32'hFFFF_FFFF, 31);         // R4: full width
        run_access(32'hFFFF_FF02, 2);          // R4: bits above cmd_len never sent

        // R9: start held high and changed cmd during a running access
        step(1, 32'h0000_0155, 8);
        for (int i = 0; i < 40; i++) step(1, 32'hDEAD_BEEF, 31);
        while (expq.size() != 0) step(0, '0, 0);

        // R9: back-to-back start in the done cycle is accepted
        step(1, 32'h0000_0006, 2);
        while (expq.size() != 0) step(0, '0, 0);
        step(1, 32'h0000_0019, 4);
        while (expq.size() != 0) step(0, '0, 0);
        idle(3);

        for (int t = 0; t < 10; t++) begin
            run_access($urandom, int'($urandom_range(0, CW-1)));
            idle(int'($urandom_range(0, 3)));
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule